// File: doc/BRIEF.md
# Fall-Through Word Queue with Ready Handshake

This block is a first-in first-out store built as a chain of one-word stages. Each stage holds a data word and an occupied flag. A word written at the input end advances one stage per clock toward the output end, but only into an empty stage. A location freed at the output end travels back toward the input one stage per clock. The input-ready flag reflects the input stage alone, and the output-ready flag reflects the output stage alone. No occupancy counter exists.

Writes and reads are pulse driven. A high level on the write strobe loads at most one word, on the first clock at which the input stage is free. A high level on the read strobe removes at most one word. Instances cascade without glue logic. The upstream output-ready drives the downstream write strobe. The upstream data output drives the downstream data input. The downstream input-ready drives the upstream read strobe. A transfer between the two then happens on a single clock, in both instances at once.

Top module: `ft_fifo`

## Requirements
- R1: One instance holds DEPTH words of WIDTH bits (defaults 64 and 5), and two cascaded instances hold 128. Words leave in the order they were loaded, and while `out_ready` is high `dout` shows the oldest stored word.
- R2: While `mr_n` is low on a clock edge all stages become empty. After reset, `in_ready` is 1 and `out_ready` is 0.
- R3: `in_ready` is low whenever the input stage is occupied, which includes the case where every location is full. A write strobe that rises and falls while `in_ready` is low loads nothing.
- R4: `out_ready` is low when the output stage holds no word. A read strobe that rises and falls while `out_ready` is low removes nothing and leaves `dout` unchanged.
- R5: After the last stored word has been removed, `dout` keeps showing that word until a new word reaches the output stage.
- R6: Each high period of `shift_in` loads at most one word. The load happens on the first clock edge at which `shift_in` and `in_ready` are both high. Each high period of `shift_out` removes at most one word, on the first edge at which `shift_out` and `out_ready` are both high.
- R7: A word moves one stage per clock and only into an empty stage. A word loaded at edge t into an empty instance raises `out_ready` after edge t+DEPTH-1. Through an empty two-instance cascade it appears after edge t+2*DEPTH-1.
- R8: A location freed at the output end raises `in_ready` only when it reaches the input stage. In a full two-instance cascade, a read at edge e raises the upstream `in_ready` after edge e+2*DEPTH-1 and not before.
- R9: In a cascade, the upstream `out_ready` stays high while its output word waits for room downstream. If `shift_in` is held high while the cascade is full, exactly one word is accepted when the freed location reaches the input, and `in_ready` drops again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mr_n | input | 1 | Synchronous master reset, active low |
| shift_in | input | 1 | Write strobe; each high period loads at most one word |
| din | input | WIDTH | Word to load |
| in_ready | output | 1 | High when the input stage is empty |
| shift_out | input | 1 | Read strobe; each high period removes at most one word |
| dout | output | WIDTH | Word in the output stage; kept after removal |
| out_ready | output | 1 | High when the output stage holds a word |

## Verification
The bench cascades two instances and runs them against a queue model. It uses four stimulus patterns. A single word sent through an empty cascade measures the exact forward latency. A complete fill followed by a complete drain checks capacity, order and the boundary flags. One read from a full cascade, with the write strobe held high, times the return of the freed slot and shows that only one word is accepted. A stream of overlapping writes and reads exercises concurrent movement in both directions, where a lost, duplicated or reordered word appears as an output that differs from the model's queue head.

// File: rtl/ft_fifo.sv
module ft_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic [WIDTH-1:0] dout,
  output logic             out_ready
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] full_q;
  logic [WIDTH-1:0] word_q [DEPTH];
  logic [DEPTH-2:0] adv;
  logic             si_used, so_used;

  wire load = shift_in  && !si_used && !full_q[0];
  wire pop  = shift_out && !so_used &&  full_q[LAST];

  assign in_ready  = !full_q[0];
  assign out_ready = full_q[LAST];
  assign dout      = word_q[LAST];

  always_ff @(posedge clk) begin
    if (!mr_n) begin
      si_used <= 1'b0;
      so_used <= 1'b0;
    end else begin
      si_used <= load ? 1'b1 : (shift_in  ? si_used : 1'b0);
      so_used <= pop  ? 1'b1 : (shift_out ? so_used : 1'b0);
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k < LAST) begin : g_adv
      assign adv[k] = full_q[k] && !full_q[k+1];
    end

    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!mr_n) begin
          full_q[0] <= 1'b0;
          word_q[0] <= '0;
        end else if (load) begin
          full_q[0] <= 1'b1;
          word_q[0] <= din;
        end else if (adv[0]) begin
          full_q[0] <= 1'b0;
        end
      end
    end else if (k == LAST) begin : g_tail
      always_ff @(posedge clk) begin
        if (!mr_n) begin
          full_q[k] <= 1'b0;
          word_q[k] <= '0;
        end else if (adv[k-1]) begin
          full_q[k] <= 1'b1;
          word_q[k] <= word_q[k-1];
        end else if (pop) begin
          full_q[k] <= 1'b0;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!mr_n) begin
          full_q[k] <= 1'b0;
          word_q[k] <= '0;
        end else if (adv[k-1]) begin
          full_q[k] <= 1'b1;
          word_q[k] <= word_q[k-1];
        end else if (adv[k]) begin
          full_q[k] <= 1'b0;
        end
      end
    end

    if (k < LAST) begin : g_chk
      a_r7_one_hop: assert property (@(posedge clk) disable iff (!mr_n)
        adv[k] |=> !full_q[k] && full_q[k+1] && word_q[k+1] == $past(word_q[k]));
    end
  end

  a_r3_load_blocks: assert property (@(posedge clk) disable iff (!mr_n)
    load |=> !in_ready);

  a_r6_pop_clears: assert property (@(posedge clk) disable iff (!mr_n)
    pop |=> !out_ready);

  a_r5_keep_last: assert property (@(posedge clk) disable iff (!mr_n)
    !out_ready |=> (out_ready || $stable(dout)));

  a_r1_hold_head: assert property (@(posedge clk) disable iff (!mr_n)
    (out_ready && !pop) |=> (out_ready && $stable(dout)));

  a_r8_slot_arrives: assert property (@(posedge clk) disable iff (!mr_n)
    $rose(in_ready) |-> full_q[1]);
endmodule

// File: tb/ft_fifo_tb.sv
module ft_fifo_tb;
  logic       clk = 1'b0;
  logic       mr_n, si, so;
  logic [4:0] din;
  logic       ir_a, or_a, ir_b, or_b;
  logic [4:0] d_a, d_b;

  always #4 clk = ~clk;

  ft_fifo #(.WIDTH(5), .DEPTH(64)) u_dut (
    .clk(clk), .mr_n(mr_n), .shift_in(si), .din(din), .in_ready(ir_a),
    .shift_out(ir_b), .dout(d_a), .out_ready(or_a));

  ft_fifo #(.WIDTH(5), .DEPTH(64)) u_dut2 (
    .clk(clk), .mr_n(mr_n), .shift_in(or_a), .din(d_a), .in_ready(ir_b),
    .shift_out(so), .dout(d_b), .out_ready(or_b));

  logic [4:0] q[$];
  bit si_tk, so_tk;
  int total = 0, bad = 0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit ld, pp;
    logic [4:0] popped, wd;
    ld = si && !si_tk && ir_a;
    pp = so && !so_tk && or_b;
    popped = d_b;
    wd = din;
    @(posedge clk);
    #2;
    if (pp) begin
      check(q.size() > 0 && popped == q[0], "R1 order", popped, q.size() > 0 ? int'(q[0]) : -1);
      if (q.size() > 0) void'(q.pop_front());
    end
    if (ld) q.push_back(wd);
    si_tk = ld ? 1'b1 : (si ? si_tk : 1'b0);
    so_tk = pp ? 1'b1 : (so ? so_tk : 1'b0);
    if (or_b) check(q.size() > 0 && d_b == q[0], "R1 head", d_b, q.size() > 0 ? int'(q[0]) : -1);
    if (q.size() == 128) check(!ir_a, "R3 full", ir_a, 0);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int n = 0; n < 4000 && q.size() > 0; n++) begin
      if (or_b) begin
        so = 1'b1; tick(); so = 1'b0; tick();
      end else tick();
    end
    check(q.size() == 0, "R1 drain", q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mr_n = 1'b0; si = 1'b0; so = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    mr_n = 1'b1;
    @(negedge clk);
    check(ir_a && ir_b, "R2 in_ready", ir_a, 1);
    check(!or_a && !or_b, "R2 out_ready", or_b, 0);

    din = 5'h15; si = 1'b1; tick(); si = 1'b0;
    repeat (126) tick();
    check(!or_b, "R7 early", or_b, 0);
    tick();
    check(or_b && d_b == 5'h15, "R7 arrive", d_b, 5'h15);

    so = 1'b1; tick(); so = 1'b0; tick();
    check(!or_b && d_b == 5'h15, "R5 last kept", d_b, 5'h15);
    for (int i = 0; i < 3; i++) begin
      so = 1'b1; tick(); so = 1'b0; tick();
    end
    check(!or_b && d_b == 5'h15, "R4 empty read", d_b, 5'h15);

    for (int i = 0; i < 128; i++) begin
      for (int n = 0; n < 300 && !ir_a; n++) tick();
      din = 5'((i * 7 + 3) & 31); si = 1'b1; tick(); si = 1'b0; tick();
    end
    repeat (200) tick();
    check(q.size() == 128, "R1 capacity", q.size(), 128);
    check(!ir_a, "R3 full flag", ir_a, 0);
    check(or_a, "R9 upstream waits", or_a, 1);
    for (int i = 0; i < 4; i++) begin
      din = 5'h1f; si = 1'b1; tick(); si = 1'b0; tick();
    end
    check(!ir_a && q.size() == 128, "R3 write ignored", q.size(), 128);

    din = 5'h1e; si = 1'b1; so = 1'b1; tick(); so = 1'b0;
    repeat (126) tick();
    check(!ir_a, "R8 early", ir_a, 0);
    tick();
    check(ir_a, "R8 slot back", ir_a, 1);
    tick();
    check(!ir_a && q.size() == 128, "R9 one accept", q.size(), 128);
    repeat (20) tick();
    si = 1'b0; tick();
    check(q.size() == 128 && q[127] == 5'h1e, "R9 held strobe", q.size(), 128);

    drain();
    check(!or_b && d_b == 5'h1e, "R5 last after drain", d_b, 5'h1e);

    for (int i = 0; i < 150; i++) begin
      din = 5'((i * 13 + 5) & 31);
      si = (i % 3) != 2;
      so = (i % 2) == 0;
      tick();
    end
    si = 1'b0; so = 1'b0; tick();
    check(q.size() > 0, "R6 stream kept words", q.size(), 1);
    drain();

    for (int i = 0; i < 3; i++) begin
      din = 5'(i + 9); si = 1'b1; tick(); si = 1'b0; tick();
    end
    mr_n = 1'b0;
    repeat (2) @(negedge clk);
    mr_n = 1'b1;
    q.delete(); si_tk = 1'b0; so_tk = 1'b0;
    @(negedge clk);
    check(ir_a && ir_b, "R2 reset in_ready", ir_a, 1);
    check(!or_a && !or_b, "R2 reset out_ready", or_b, 0);
    repeat (140) tick();
    check(!or_b, "R2 nothing left", or_b, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule